// File: doc/BRIEF.md
# Display RAM Address Mapper

This block turns a position on a 16-character panel into the display-RAM address that the fetch logic should read for that position. The panel is built as two halves of eight character cells. One half is driven on commons 1 to 8 and the other on commons 9 to 16. The caller supplies a cell column, a half select, an addressing-mode bit and a shift command. One clock later the block returns the 7-bit address to fetch.

There are two address maps. In the single-line map (mode 0), the sixteen cells read a contiguous range from 00h to 0Fh. In the split map (mode 1), the first half reads 00h to 07h and the second half reads 40h to 47h. An internal shift offset makes the whole display scroll circularly. A left shift moves the contents one place toward the left edge, and a right shift moves them toward the right edge. The offset wraps inside the active range. In mode 1, each line wraps on its own. A return-home strobe sets the offset back to zero.

Top module: `dram_addr_map`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addr_o` is 00h and the shift offset is zero.
- R2: In mode 0 (`mode_i`=0), the address is (`half_i`*8 + `col_i` + offset) mod 16, so it always lies in 00h..0Fh. `half_i`=0 selects commons 1 to 8 and `half_i`=1 selects commons 9 to 16.
- R3: In mode 1 (`mode_i`=1), the address is (`col_i` + offset) mod 8, plus 40h when `half_i`=1.
- R4: Shift code 01 (left) adds one to the offset, modulo 16. After one left shift from zero in mode 0, the leftmost cell (half 0, column 0) shows 01h and the rightmost cell (half 1, column 7) shows 00h.
- R5: Shift code 10 (right) subtracts one from the offset, modulo 16. After one right shift from zero in mode 0, the leftmost cell shows 0Fh and the next cell shows 00h.
- R6: In mode 1, each line wraps inside its own eight addresses. The first line never leaves 00h..07h and the second never leaves 40h..47h, whatever the offset.
- R7: `home_i`=1 clears the offset to zero and takes priority over any shift code in the same cycle.
- R8: Shift codes 00 and 11 leave the offset unchanged.
- R9: `addr_o` is registered. It reflects the inputs (and the offset) present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_i | input | 3 | Cell column within a half, 0 = left |
| half_i | input | 1 | 0 = commons 1 to 8 (first line), 1 = commons 9 to 16 (second line) |
| mode_i | input | 1 | 0 = single-line map, 1 = split two-line map |
| shift_i | input | 2 | 00 none, 01 left, 10 right, 11 none |
| home_i | input | 1 | Return-home strobe, clears the shift offset |
| addr_o | output | 7 | Display-RAM address for the requested cell |

## Verification
A shift or home strobe sampled at one rising edge changes the offset at that edge. The offset first appears in `addr_o` one edge later, when the mapping register loads. The bench therefore issues each command for one cycle and clears it. Only after that does it start a sweep. For each cell query, the bench drives the column, half and mode on a falling edge and reads `addr_o` on the following falling edge. This is exactly one register stage later. One extra check samples just after a change of input to confirm that the old address is still held. After every step, the bench recomputes the expected address arithmetically from its own copy of the offset.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] LINE2_BASE = 7'h40;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_RSVD  = 2'b11
  } shift_cmd_e;
endpackage

// File: rtl/dram_shift_ofs.sv
module dram_shift_ofs #(
  parameter int unsigned OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       shift_i,
  input  logic             home_i,
  output logic [OFS_W-1:0] ofs_o
);
  import dram_map_pkg::*;

  // named events for the checks below
  logic ev_home, ev_left, ev_right, ev_idle;
  assign ev_home  = home_i;
  assign ev_left  = !home_i && (shift_i == SH_LEFT);
  assign ev_right = !home_i && (shift_i == SH_RIGHT);
  assign ev_idle  = !ev_home && !ev_left && !ev_right;

  logic [OFS_W-1:0] ofs_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        ofs_q <= '0;
    else if (ev_home)  ofs_q <= '0;
    else if (ev_left)  ofs_q <= ofs_q + 1'b1;
    else if (ev_right) ofs_q <= ofs_q - 1'b1;
  end
  assign ofs_o = ofs_q;

  a_r4_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ev_left) |-> ofs_o == OFS_W'($past(ofs_o) + 1'b1));
  a_r5_right_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ev_right) |-> ofs_o == OFS_W'($past(ofs_o) - 1'b1));
  a_r7_home_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(home_i) |-> ofs_o == '0);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ev_idle) |-> $stable(ofs_o));
endmodule

// File: rtl/dram_addr_calc.sv
module dram_addr_calc #(
  parameter  int unsigned COLS   = 8,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned OFS_W  = COL_W + 1,
  localparam int unsigned ADDR_W = dram_map_pkg::ADDR_W
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic              half_i,
  input  logic              mode_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] addr_o
);
  import dram_map_pkg::*;

  // single line: both halves form one circular range of 2*COLS cells
  function automatic logic [ADDR_W-1:0] one_line_addr(
    input logic half, input logic [COL_W-1:0] col, input logic [OFS_W-1:0] ofs);
    logic [OFS_W-1:0] pos;
    pos = {half, col} + ofs;
    return ADDR_W'(pos);
  endfunction

  // split: each half wraps within its own COLS cells
  function automatic logic [ADDR_W-1:0] two_line_addr(
    input logic half, input logic [COL_W-1:0] col, input logic [OFS_W-1:0] ofs);
    logic [COL_W-1:0] idx;
    idx = col + ofs[COL_W-1:0];
    return (half ? LINE2_BASE : '0) | ADDR_W'(idx);
  endfunction

  logic [ADDR_W-1:0] addr_one, addr_two;
  assign addr_one = one_line_addr(half_i, col_i, ofs_i);
  assign addr_two = two_line_addr(half_i, col_i, ofs_i);
  assign addr_o   = mode_i ? addr_two : addr_one;
endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter  int unsigned COLS   = 8,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned OFS_W  = COL_W + 1,
  localparam int unsigned ADDR_W = dram_map_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COL_W-1:0]  col_i,
  input  logic              half_i,
  input  logic              mode_i,
  input  logic [1:0]        shift_i,
  input  logic              home_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] addr_next;

  dram_shift_ofs #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_i), .home_i(home_i), .ofs_o(ofs)
  );

  dram_addr_calc #(.COLS(COLS)) u_calc (
    .col_i(col_i), .half_i(half_i), .mode_i(mode_i), .ofs_i(ofs), .addr_o(addr_next)
  );

  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_next;
  end
  assign addr_o = addr_q;

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (addr_o == '0) && (ofs == '0));
  a_r2_single_range: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(mode_i) |-> (addr_o >> OFS_W) == '0);
  a_r3_line_select: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode_i) |-> addr_o[ADDR_W-1] == $past(half_i));
  a_r6_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode_i) |-> addr_o[ADDR_W-2:COL_W] == '0);
  a_r9_registered: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> addr_o == $past(addr_next));
endmodule

// File: tb/tb_dram_addr_map.sv
module tb_dram_addr_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] col_i = '0;
  logic       half_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [1:0] shift_i = 2'b00;
  logic       home_i = 1'b0;
  logic [6:0] addr_o;

  int checks = 0;
  int fails  = 0;
  int m_ofs  = 0;   // bench model of the shift offset

  always #2.5 clk = ~clk;   // 200 MHz

  dram_addr_map dut (
    .clk(clk), .rst_n(rst_n), .col_i(col_i), .half_i(half_i), .mode_i(mode_i),
    .shift_i(shift_i), .home_i(home_i), .addr_o(addr_o)
  );

  function automatic int expect_addr(int c, int h, int m, int o);
    if (m == 0) return (h * 8 + c + o) % 16;
    return h * 64 + ((c + o) % 8);
  endfunction

  task automatic compare(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: addr actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic query(int c, int h, int m, string req);
    @(negedge clk);
    col_i = 3'(c); half_i = h[0]; mode_i = m[0];
    @(negedge clk);
    compare(req, int'(addr_o), expect_addr(c, h, m, m_ofs));
  endtask

  task automatic command(logic [1:0] cmd, logic hm);
    @(negedge clk);
    shift_i = cmd; home_i = hm;
    @(negedge clk);
    shift_i = 2'b00; home_i = 1'b0;
    if (hm) m_ofs = 0;
    else if (cmd == 2'b01) m_ofs = (m_ofs + 1) % 16;
    else if (cmd == 2'b10) m_ofs = (m_ofs + 15) % 16;
  endtask

  task automatic sweep(string req);
    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 8; c++)
          query(c, h, m, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset", int'(addr_o), 0);
    rst_n = 1'b1;
    #1 compare("R1 after release", int'(addr_o), 0);

    // R2/R3 base maps with zero offset
    sweep("R2/R3 base map");
    query(7, 1, 0, "R2 last cell");
    query(7, 1, 1, "R3 line2 end");

    // R4 single left shift corner values
    command(2'b01, 1'b0);
    query(0, 0, 0, "R4 leftmost after left");
    compare("R4 leftmost literal", int'(addr_o), 1);
    query(7, 1, 0, "R4 rightmost after left");
    compare("R4 rightmost literal", int'(addr_o), 0);

    // R4/R6 full left sweep through every offset, both maps
    for (int s = 0; s < 16; s++) begin
      sweep("R4/R6 left sweep");
      command(2'b01, 1'b0);
    end

    // R7 home
    command(2'b00, 1'b1);
    query(0, 0, 0, "R7 home clears");
    compare("R7 home literal", int'(addr_o), 0);

    // R5 single right shift
    command(2'b10, 1'b0);
    query(0, 0, 0, "R5 leftmost after right");
    compare("R5 leftmost literal", int'(addr_o), 15);
    query(1, 0, 0, "R5 second cell after right");
    compare("R5 second literal", int'(addr_o), 0);
    query(0, 0, 1, "R6 line1 after right");
    compare("R6 line1 literal", int'(addr_o), 7);
    query(0, 1, 1, "R6 line2 after right");
    compare("R6 line2 literal", int'(addr_o), 'h47);

    // R5/R6 right sweep
    for (int s = 0; s < 16; s++) begin
      command(2'b10, 1'b0);
      sweep("R5/R6 right sweep");
    end

    // R8 idle codes keep offset
    command(2'b01, 1'b0);
    command(2'b01, 1'b0);
    command(2'b11, 1'b0);
    command(2'b00, 1'b0);
    sweep("R8 idle codes hold");

    // R7 home wins over a shift in the same cycle
    command(2'b01, 1'b1);
    sweep("R7 home priority");

    // R9 one-cycle latency
    query(3, 0, 0, "R9 setup");
    @(negedge clk);
    col_i = 3'd5; half_i = 1'b1; mode_i = 1'b1;
    #1 compare("R9 old value held", int'(addr_o), expect_addr(3, 0, 0, m_ofs));
    @(negedge clk);
    compare("R9 new value", int'(addr_o), expect_addr(5, 1, 1, m_ofs));

    // R1 reset mid-run clears offset
    command(2'b01, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_ofs = 0;
    #1 compare("R1 reset mid-run", int'(addr_o), 0);
    query(0, 0, 0, "R1 offset zero after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule